// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block is the master side of a single-wire, open-drain bus. All bus timing is counted in microseconds from a one-cycle `tick_us` strobe supplied by the surrounding logic. A command takes an operation code, a byte count and a start strobe. The engine then carries out one of three operations: a bus reset with presence detection, a byte write, or a byte read. The data moves through a small internal byte buffer. The host fills that buffer before a write and reads it back after a read.

Each operation is a sequence of fixed-length time slots. At the start of every slot the engine drives the line low and releases it once a per-slot count is reached. Each slot also records the moment of the first rising edge on the synchronised line after the release. A read bit, or the presence of a device, is decided from that moment and not from a single fixed sample point. In multi-byte transfers the buffer is walked from the highest used index down to index 0. Bits move least-significant first.

Top module: `owm_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `presence` and `line_drive_low` are all 0.
- R2: Operation code 0 (bus reset) runs one slot of 1000 ticks, with the line driven low for the first 500 ticks.
- R3: At the end of a bus reset, `presence` becomes 1 if the first rising edge after release was captured later than 550 ticks into the slot, and 0 otherwise. `presence` changes only in the cycle where `done` is high.
- R4: Operation code 1 (write) sends 70-tick slots, eight per byte, least-significant bit first. A 0 bit holds the line low for 60 ticks and a 1 bit for 6 ticks.
- R5: A write of N bytes sends buffer index N-1 first and index 0 last. `cmd_len` values 0 and above 10 are taken as 1 and 10.
- R6: Operation code 2 (read) uses 70-tick slots with a 2-tick low pulse. A rising edge captured before tick 12 gives a 1. A later edge gives a 0, and so does no edge within the slot, since the capture then holds the slot length.
- R7: A read of N bytes assembles each byte least-significant bit first. The first byte received is stored at buffer index N-1 and the last at index 0.
- R8: `busy` rises in the cycle after an accepted start and stays high through every tick of every slot. `done` is a one-cycle pulse in the cycle where `busy` falls. The total number of ticks seen while `busy` is high equals the sum of the slot lengths.
- R9: A start while `busy` is high is ignored. A start with operation code 3 is ignored: `busy` stays low and the line is not driven.
- R10: Host buffer writes are taken only while idle; a write attempted while `busy` is high leaves the entry unchanged. `buf_rd_data` shows the entry at `buf_rd_idx` without delay.
- R11: `line_drive_low` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| cmd_op | input | 2 | Operation: 0 reset, 1 write, 2 read, 3 reserved |
| cmd_len | input | 4 | Byte count for write or read |
| cmd_start | input | 1 | Start strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | Result of the last bus reset |
| buf_wr_en | input | 1 | Host buffer write enable |
| buf_wr_idx | input | 4 | Host buffer write index |
| buf_wr_data | input | 8 | Host buffer write data |
| buf_rd_idx | input | 4 | Host buffer read index |
| buf_rd_data | output | 8 | Buffer entry at `buf_rd_idx` |
| line_drive_low | output | 1 | Pull the bus line low when 1 |
| line_in | input | 1 | Raw bus line level |

## Verification
The assertions assume two things about the inputs. First, `tick_us` is a single-cycle strobe separated by at least one idle cycle. Second, the line rises only when both the master and the device model have let go. The bench therefore makes `tick_us` high on every other clock. The line is derived as the wired-AND of `line_drive_low` and a bench device model that pulls low during fixed windows measured in ticks from each slot start. The presence window overlaps the master's low pulse, so no edge appears at release. Read-0 pulls end near tick 15, and a stuck-low bit holds the line for the whole slot. All host inputs change one step after a rising clock edge.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_NONE  = 2'd3
  } owm_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } owm_st_e;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             slot_go,
  input  logic [CNT_W-1:0] len_in,
  input  logic [CNT_W-1:0] low_in,
  input  logic             line_s,
  output logic             drive_low,
  output logic             slot_end,
  output logic [CNT_W-1:0] cap
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] low_q, low_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             got_q, got_d;
  logic             prev_q;
  logic             rise;
  logic             last_tick;

  assign rise      = line_s & ~prev_q;
  assign last_tick = active_q & tick & (cnt_q == len_q - 1'b1);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    low_d    = low_q;
    cap_d    = cap_q;
    got_d    = got_q;
    if (slot_go) begin
      active_d = 1'b1;
      cnt_d    = '0;
      len_d    = len_in;
      low_d    = low_in;
      cap_d    = len_in;
      got_d    = 1'b0;
    end else if (active_q) begin
      if (rise && !got_q && (cnt_q >= low_q)) begin
        cap_d = cnt_q;
        got_d = 1'b1;
      end
      if (tick) begin
        if (last_tick) active_d = 1'b0;
        else           cnt_d    = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      low_q    <= '0;
      cap_q    <= '0;
      got_q    <= 1'b0;
      prev_q   <= 1'b1;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
      low_q    <= low_d;
      cap_q    <= cap_d;
      got_q    <= got_d;
      prev_q   <= line_s;
    end
  end

  assign drive_low = active_q && (cnt_q < low_q);
  assign slot_end  = last_tick;
  assign cap       = cap_q;

  // R6
  cnt_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < len_q));

  // R3
  first_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q && !slot_go) |=> $stable(cap_q));
endmodule

// File: rtl/owm_byte_buf.sv
module owm_byte_buf #(
  parameter int DEPTH = 10,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_widx,
  input  logic [7:0]       host_wdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_widx,
  input  logic [7:0]       eng_wdata,
  input  logic [IDX_W-1:0] host_ridx,
  output logic [7:0]       host_rdata,
  input  logic [IDX_W-1:0] eng_ridx,
  output logic [7:0]       eng_rdata
);
  logic [7:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic       sel_eng, sel_host;
    logic [7:0] ent_d;
    assign sel_eng  = eng_we  && (eng_widx  == IDX_W'(e));
    assign sel_host = host_we && (host_widx == IDX_W'(e));
    always_comb begin
      ent_d = mem_q[e];
      if (sel_eng)       ent_d = eng_wdata;
      else if (sel_host) ent_d = host_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[e] <= '0;
      else        mem_q[e] <= ent_d;
    end
  end

  assign host_rdata = (int'(host_ridx) < DEPTH) ? mem_q[host_ridx] : 8'h00;
  assign eng_rdata  = (int'(eng_ridx)  < DEPTH) ? mem_q[eng_ridx]  : 8'h00;
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int RST_SLOT   = 1000,
  parameter int RST_LOW    = 500,
  parameter int PRES_MIN   = 550,
  parameter int BIT_SLOT   = 70,
  parameter int W0_LOW     = 60,
  parameter int W1_LOW     = 6,
  parameter int RD_LOW     = 2,
  parameter int RD_THRESH  = 12,
  parameter int MAX_BYTES  = 10,
  parameter int LEN_W      = 4,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic [1:0]       cmd_op,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             cmd_start,
  output logic             busy,
  output logic             done,
  output logic             presence,
  input  logic             buf_wr_en,
  input  logic [IDX_W-1:0] buf_wr_idx,
  input  logic [7:0]       buf_wr_data,
  input  logic [IDX_W-1:0] buf_rd_idx,
  output logic [7:0]       buf_rd_data,
  output logic             line_drive_low,
  input  logic             line_in
);
  localparam int CNT_W = $clog2(RST_SLOT + 1);

  owm_st_e          st_q, st_d;
  owm_op_e          op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             done_q, done_d;
  logic             pres_q, pres_d;

  logic             line_s;
  logic             slot_go, slot_end;
  logic [CNT_W-1:0] slot_len, slot_low, cap;
  logic             accept;
  logic [LEN_W-1:0] len_cl;
  logic [IDX_W-1:0] first_idx, eng_ridx, eng_widx;
  logic [7:0]       eng_rdata, eng_wdata, rx_byte;
  logic             eng_we, rx_bit;

  owm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
  );

  owm_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_us), .slot_go(slot_go),
    .len_in(slot_len), .low_in(slot_low), .line_s(line_s),
    .drive_low(line_drive_low), .slot_end(slot_end), .cap(cap)
  );

  owm_byte_buf #(.DEPTH(MAX_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .host_we(buf_wr_en && (st_q == ST_IDLE)), .host_widx(buf_wr_idx),
    .host_wdata(buf_wr_data),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wdata(eng_wdata),
    .host_ridx(buf_rd_idx), .host_rdata(buf_rd_data),
    .eng_ridx(eng_ridx), .eng_rdata(eng_rdata)
  );

  always_comb begin
    if (cmd_len == '0)                        len_cl = LEN_W'(1);
    else if (cmd_len > LEN_W'(MAX_BYTES))     len_cl = LEN_W'(MAX_BYTES);
    else                                      len_cl = cmd_len;
  end

  assign accept    = cmd_start && (st_q == ST_IDLE) && (owm_op_e'(cmd_op) != OP_NONE);
  assign first_idx = IDX_W'(len_cl - 1'b1);
  assign eng_ridx  = accept ? first_idx : (idx_q - 1'b1);
  assign rx_bit    = (cap < CNT_W'(RD_THRESH));
  assign rx_byte   = {rx_bit, sh_q[7:1]};

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    idx_d     = idx_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    done_d    = 1'b0;
    pres_d    = pres_q;
    slot_go   = 1'b0;
    slot_len  = CNT_W'(BIT_SLOT);
    slot_low  = CNT_W'(RD_LOW);
    eng_we    = 1'b0;
    eng_widx  = idx_q;
    eng_wdata = rx_byte;
    if (st_q == ST_IDLE) begin
      if (accept) begin
        st_d    = ST_RUN;
        op_d    = owm_op_e'(cmd_op);
        idx_d   = first_idx;
        bit_d   = '0;
        slot_go = 1'b1;
        case (owm_op_e'(cmd_op))
          OP_RESET: begin
            slot_len = CNT_W'(RST_SLOT);
            slot_low = CNT_W'(RST_LOW);
          end
          OP_WRITE: begin
            sh_d     = eng_rdata;
            slot_low = eng_rdata[0] ? CNT_W'(W1_LOW) : CNT_W'(W0_LOW);
          end
          default: begin
            sh_d     = '0;
          end
        endcase
      end
    end else if (slot_end) begin
      case (op_q)
        OP_RESET: begin
          pres_d = (cap > CNT_W'(PRES_MIN));
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
        OP_WRITE: begin
          if (bit_q == 3'd7) begin
            if (idx_q == '0) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              idx_d    = idx_q - 1'b1;
              sh_d     = eng_rdata;
              bit_d    = '0;
              slot_go  = 1'b1;
              slot_low = eng_rdata[0] ? CNT_W'(W1_LOW) : CNT_W'(W0_LOW);
            end
          end else begin
            sh_d     = {1'b0, sh_q[7:1]};
            bit_d    = bit_q + 1'b1;
            slot_go  = 1'b1;
            slot_low = sh_q[1] ? CNT_W'(W1_LOW) : CNT_W'(W0_LOW);
          end
        end
        default: begin
          sh_d = rx_byte;
          if (bit_q == 3'd7) begin
            eng_we = 1'b1;
            if (idx_q == '0) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              idx_d   = idx_q - 1'b1;
              bit_d   = '0;
              slot_go = 1'b1;
            end
          end else begin
            bit_d   = bit_q + 1'b1;
            slot_go = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_RESET;
      idx_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      pres_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      pres_q <= pres_d;
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign done     = done_q;
  assign presence = pres_q;

  // R8
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(busy)));

  // R11
  drive_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> busy);

  // R9
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start) |=> $stable(op_q));

  // R3
  presence_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_q != $past(pres_q)) |-> done_q);
endmodule

// File: tb/owm_engine_bench.sv
module owm_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_len = 4'd1;
  logic       cmd_start = 1'b0;
  logic       busy, done, presence;
  logic       buf_wr_en = 1'b0;
  logic [3:0] buf_wr_idx = 4'd0;
  logic [7:0] buf_wr_data = 8'd0;
  logic [3:0] buf_rd_idx = 4'd0;
  logic [7:0] buf_rd_data;
  logic       line_drive_low;
  logic       dev_pull = 1'b0;
  logic       line_in;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  int exp_low[$];
  int dev_bits[$];
  int dev_mode = 0;
  int cur_code = 1;
  int dticks = 0;
  int pulse_w = 0;
  int busy_ticks = 0;
  logic prev_drv = 1'b0;
  logic prev_done = 1'b0;

  always #4 clk = ~clk;

  assign line_in = !(line_drive_low || dev_pull);

  owm_engine u_owm_engine (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_start(cmd_start),
    .busy(busy), .done(done), .presence(presence),
    .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
    .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .line_drive_low(line_drive_low), .line_in(line_in)
  );

  always @(posedge clk) tick_us <= #1 (rst_n ? ~tick_us : 1'b0);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural monitor and device model, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (line_drive_low && !prev_drv) begin
        dticks = tick_us ? 1 : 0;
        pulse_w = tick_us ? 1 : 0;
        if (dev_mode == 2) cur_code = (dev_bits.size() > 0) ? dev_bits.pop_front() : 1;
      end else begin
        if (tick_us) dticks++;
        if (line_drive_low && tick_us) pulse_w++;
      end
      if (!line_drive_low && prev_drv) begin
        if (exp_low.size() == 0) chk(0, "R4 unexpected pulse", pulse_w, 0);
        else begin
          int e;
          e = exp_low.pop_front();
          chk(pulse_w == e, "R2/R4/R6 low pulse width", pulse_w, e);
        end
      end
      if (busy && tick_us) busy_ticks++;
      chk(!(line_drive_low && !busy), "R11 drive while idle", line_drive_low, 0);
      chk(!(done && busy), "R8 done with busy", busy, 0);
      chk(!(done && prev_done), "R8 done width", 2, 1);
      case (dev_mode)
        1: dev_pull = (dticks >= 480) && (dticks < 650);
        2: dev_pull = (cur_code == 0) ? (dticks < 15) : (cur_code == 2) ? (dticks < 70) : 1'b0;
        default: dev_pull = 1'b0;
      endcase
      prev_drv = line_drive_low;
      prev_done = done;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic issue(input int op, input int len);
    busy_ticks = 0;
    cmd_op = op[1:0]; cmd_len = len[3:0]; cmd_start = 1'b1;
    step();
    cmd_start = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done && !finished) @(negedge clk);
  endtask

  task automatic load(input int idx, input logic [7:0] d);
    buf_wr_en = 1'b1; buf_wr_idx = idx[3:0]; buf_wr_data = d;
    step();
    buf_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int idx, input logic [7:0] exp, input string req);
    buf_rd_idx = idx[3:0];
    @(negedge clk);
    chk(buf_rd_data == exp, req, buf_rd_data, exp);
    step();
  endtask

  task automatic push_write(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_low.push_back(b[i] ? 6 : 60);
  endtask

  task automatic push_read(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_low.push_back(2);
      dev_bits.push_back(b[i] ? 1 : 0);
    end
  endtask

  initial begin : watchdog
    wait (cyc >= 190000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] wb [3];
    logic [7:0] rb [10];
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(presence == 0, "R1 presence", presence, 0);
    chk(line_drive_low == 0, "R1 drive", line_drive_low, 0);
    step();

    // R2 R3 bus reset with a responding device
    dev_mode = 1;
    exp_low.push_back(500);
    issue(0, 1);
    @(negedge clk);
    chk(busy == 1, "R8 busy after start", busy, 1);
    wait_done();
    chk(presence == 1, "R3 presence seen", presence, 1);
    chk(busy_ticks == 1000, "R2 reset slot length", busy_ticks, 1000);
    step();

    // R3 bus reset with no device
    dev_mode = 0;
    exp_low.push_back(500);
    issue(0, 1);
    wait_done();
    chk(presence == 0, "R3 presence cleared", presence, 0);
    step();

    // R4 R5 R9 R10 write three bytes, disturbed while busy
    wb[0] = 8'h01; wb[1] = 8'h3C; wb[2] = 8'hA5;
    for (int i = 0; i < 3; i++) load(i, wb[i]);
    for (int i = 2; i >= 0; i--) push_write(wb[i]);
    issue(1, 3);
    repeat (200) step();
    cmd_op = 2'd2; cmd_len = 4'd1; cmd_start = 1'b1;
    buf_wr_en = 1'b1; buf_wr_idx = 4'd0; buf_wr_data = 8'hEE;
    step();
    cmd_start = 1'b0; buf_wr_en = 1'b0;
    wait_done();
    chk(busy_ticks == 24 * 70, "R4 R9 write slot total", busy_ticks, 24 * 70);
    chk(exp_low.size() == 0, "R5 all write pulses", exp_low.size(), 0);
    step();
    rd_chk(0, 8'h01, "R10 host write while busy ignored");
    rd_chk(2, 8'hA5, "R10 buffer readback");

    // R6 R7 read two bytes
    dev_mode = 2;
    push_read(8'h5A); push_read(8'hC3);
    issue(2, 2);
    wait_done();
    chk(busy_ticks == 16 * 70, "R6 read slot total", busy_ticks, 16 * 70);
    step();
    rd_chk(1, 8'h5A, "R7 first byte at top index");
    rd_chk(0, 8'hC3, "R7 last byte at index 0");

    // R6 stuck-low bit reads as 0
    for (int i = 0; i < 8; i++) begin
      exp_low.push_back(2);
      dev_bits.push_back(i == 3 ? 2 : 1);
    end
    issue(2, 1);
    wait_done();
    step();
    rd_chk(0, 8'hF7, "R6 no edge gives 0");

    // R5 R7 maximum length read, length clamp
    for (int k = 0; k < 10; k++) begin
      rb[k] = 8'(k * 8'h1D) ^ 8'h96;
      push_read(rb[k]);
    end
    issue(2, 15);
    wait_done();
    chk(busy_ticks == 80 * 70, "R5 clamp to ten bytes", busy_ticks, 80 * 70);
    step();
    for (int k = 0; k < 10; k++) rd_chk(9 - k, rb[k], "R7 ten byte order");
    dev_mode = 0;

    // R9 reserved op code
    issue(3, 1);
    repeat (4) begin
      @(negedge clk);
      chk(busy == 0 && line_drive_low == 0, "R9 reserved op ignored", busy, 0);
    end
    chk(exp_low.size() == 0, "R9 no stray pulses", exp_low.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule